// File: doc/BRIEF.md
# Two-Level Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters that is split into several counter sets. A short global history register records the outcomes of the most recently resolved branches. Its current value chooses which set answers for a given branch address, so that one branch can learn different behaviour depending on the path that led to it.

The fetch side presents a PC and reads back a combinational prediction bit in the same cycle. When a branch resolves, the back end presents that branch's PC, its actual direction and a valid strobe. The counter selected by the history value at that moment moves one step toward the outcome. In the same cycle the outcome is shifted into the history register. Low PC bits above the instruction alignment bits form the row index.

Top module: `two_level_bp`

## Requirements
- R1: After reset every counter is weakly-not-taken, so every lookup predicts not-taken (0), and the history register is zero.
- R2: The prediction is the upper bit of the counter at row fetch_pc_i[IDX_W+1:2] in the set numbered by the current history value (1 = taken).
- R3: A resolved taken outcome increments the selected counter and saturates at 3. A resolved not-taken outcome decrements it and saturates at 0. Encoding: 0 strong-not-taken, 1 weak-not-taken, 2 weak-taken, 3 strong-taken.
- R4: A counter in a strong state changes its predicted direction only after two consecutive opposite outcomes.
- R5: Each valid resolve shifts its outcome into bit 0 of the history, and the older bits move one place up.
- R6: An update writes the counter in the set chosen by the history value before that resolve's own shift.
- R7: A lookup in the same cycle as an update to the same counter returns the pre-update prediction. The new value is seen from the next cycle on.
- R8: While res_valid_i is low, res_pc_i and res_taken_i have no effect on counters or history.
- R9: PC bits [1:0] and the bits above IDX_W+1 do not affect indexing, so PCs that differ only there share a counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_pc_i | input | PC_W | PC being looked up |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| res_valid_i | input | 1 | A branch resolves this cycle |
| res_pc_i | input | PC_W | PC of the resolving branch |
| res_taken_i | input | 1 | Actual direction of the resolving branch |

## Verification
A history register that is wrong, or shifted in the wrong order, makes the prediction for a trained branch read from the wrong set on the next lookup. This can be seen one cycle after the faulty resolve. A counter that skips a state or fails to saturate changes the direction seen at pred_taken_o one resolve too early or too late. The directed cases therefore steer the history back to a known value before each probe. A bench model tracks every counter and the history, and it compares every lookup cycle under random traffic.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'd0,
    CTR_WNT = 2'd1,
    CTR_WT  = 2'd2,
    CTR_ST  = 2'd3
  } ctr_e;

  function automatic ctr_e ctr_step(ctr_e cur, logic taken);
    ctr_e nxt;
    unique case (cur)
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      default: nxt = taken ? CTR_ST  : CTR_WT;
    endcase
    return nxt;
  endfunction

  function automatic logic ctr_dir(ctr_e cur);
    return cur[1];
  endfunction
endpackage

// File: rtl/tlbp_index.sv
module tlbp_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o
);
  // alignment bits and upper tag bits take no part in indexing
  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc_i[PC_W-1:IDX_W+2], pc_i[1:0]};
  assign idx_o = pc_i[IDX_W+1:2];
endmodule

// File: rtl/tlbp_hist.sv
module tlbp_hist #(
  parameter int HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q, hist_d;

  generate
    if (HIST_W == 1) begin : g_one
      assign hist_d = bit_i;
    end else begin : g_many
      assign hist_d = {hist_q[HIST_W-2:0], bit_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= hist_d;
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/tlbp_ctr_set.sv
module tlbp_ctr_set
  import tlbp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_dir_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_e mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= CTR_WNT;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= ctr_step(mem_q[wr_idx_i], wr_taken_i);
    end
  end

  // read sees the stored value, so a same-cycle write is not forwarded
  assign rd_dir_o = ctr_dir(mem_q[rd_idx_i]);
endmodule

// File: rtl/two_level_bp.sv
module two_level_bp #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 8,
  parameter int HIST_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            pred_taken_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i
);
  localparam int NSETS = 1 << HIST_W;

  logic [IDX_W-1:0]  fetch_idx, res_idx;
  logic [HIST_W-1:0] hist_q;
  logic [NSETS-1:0]  set_dir;

  tlbp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fetch_idx (
    .pc_i (fetch_pc_i),
    .idx_o(fetch_idx)
  );

  tlbp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_res_idx (
    .pc_i (res_pc_i),
    .idx_o(res_idx)
  );

  tlbp_hist #(.HIST_W(HIST_W)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(res_valid_i),
    .bit_i  (res_taken_i),
    .hist_o (hist_q)
  );

  // one counter set per history value; update targets the pre-shift history
  generate
    for (genvar s = 0; s < NSETS; s++) begin : g_set
      logic wr_en;
      assign wr_en = res_valid_i && (hist_q == HIST_W'(s));
      tlbp_ctr_set #(.IDX_W(IDX_W)) u_set (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_idx_i  (fetch_idx),
        .rd_dir_o  (set_dir[s]),
        .wr_en_i   (wr_en),
        .wr_idx_i  (res_idx),
        .wr_taken_i(res_taken_i)
      );
    end
  endgenerate

  assign pred_taken_o = set_dir[hist_q];
endmodule

// File: rtl/two_level_bp_chk.sv
module two_level_bp_chk #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PC_W-1:0]   fetch_pc_i,
  input logic              res_valid_i,
  input logic              res_taken_i,
  input logic              pred_taken_o,
  input logic [HIST_W-1:0] hist_q
);
  AST_HIST_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> hist_q == '0); // R1

  AST_HIST_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> hist_q == HIST_W'({$past(hist_q), $past(res_taken_i)})); // R5

  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(hist_q)); // R8

  AST_PRED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!res_valid_i) && $stable(fetch_pc_i)) |-> $stable(pred_taken_o)); // R8
endmodule

bind two_level_bp two_level_bp_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fetch_pc_i  (fetch_pc_i),
  .res_valid_i (res_valid_i),
  .res_taken_i (res_taken_i),
  .pred_taken_o(pred_taken_o),
  .hist_q      (hist_q)
);

// File: tb/sim_two_level_bp.sv
module sim_two_level_bp;
  localparam int PC_W   = 32;
  localparam int IDX_W  = 8;
  localparam int HIST_W = 2;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int NSETS  = 1 << HIST_W;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic [PC_W-1:0] res_pc = '0;
  logic            res_valid = 1'b0;
  logic            res_taken = 1'b0;
  logic            pred;

  int unsigned checks = 0;
  int unsigned errors = 0;
  int          m_ctr [NSETS][DEPTH];
  int          m_hist;

  always #5 clk = ~clk;

  two_level_bp #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .fetch_pc_i  (fetch_pc),
    .pred_taken_o(pred),
    .res_valid_i (res_valid),
    .res_pc_i    (res_pc),
    .res_taken_i (res_taken)
  );

  function automatic int m_idx(logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic int m_pred(logic [PC_W-1:0] pc);
    return (m_ctr[m_hist][m_idx(pc)] >= 2) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare against model, then advance model at posedge
  task automatic step(logic [PC_W-1:0] f, bit v, logic [PC_W-1:0] rp, bit t, string req);
    int idx;
    @(negedge clk);
    fetch_pc  = f;
    res_valid = v;
    res_pc    = rp;
    res_taken = t;
    #1;
    check(req, int'(pred), m_pred(f));
    @(posedge clk);
    if (v) begin
      idx = m_idx(rp);
      if (t) m_ctr[m_hist][idx] = (m_ctr[m_hist][idx] == 3) ? 3 : m_ctr[m_hist][idx] + 1;
      else   m_ctr[m_hist][idx] = (m_ctr[m_hist][idx] == 0) ? 0 : m_ctr[m_hist][idx] - 1;
      m_hist = ((m_hist << 1) | int'(t)) & (NSETS - 1);
    end
  endtask

  task automatic probe(logic [PC_W-1:0] f, int exp, string req);
    @(negedge clk);
    fetch_pc  = f;
    res_valid = 1'b0;
    #1;
    check(req, int'(pred), exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [PC_W-1:0] pc_a, pc_b, pc_alias;
    void'($urandom(32'd2742));
    pc_a     = 32'h0000_0100;
    pc_b     = 32'h0000_0200;
    pc_alias = 32'h0000_0503;
    for (int s = 0; s < NSETS; s++)
      for (int i = 0; i < DEPTH; i++) m_ctr[s][i] = 1;
    m_hist = 0;

    // R1: reset state
    #23;
    check("R1 in reset", int'(pred), 0);
    rst_ni = 1'b1;
    probe(pc_a, 0, "R1 after reset A");
    probe(32'hFFFF_FFFC, 0, "R1 after reset high PC");

    // train A taken: sets 0,1 -> WT, set 3 -> ST, history ends at 3
    repeat (4) step(pc_a, 1'b1, pc_a, 1'b1, "R3 train");
    probe(pc_a, 1, "R2 strong taken in set 3");
    probe(pc_alias, 1, "R9 alias of A");
    probe(pc_b, 0, "R2 untrained B");

    // one miss: set3[A] ST->WT, history 2 selects untouched set
    step(pc_a, 1'b1, pc_a, 1'b0, "R6 miss 1");
    probe(pc_a, 0, "R2 history 2 picks other set");
    step(pc_b, 1'b1, pc_b, 1'b1, "R5 steer");
    step(pc_b, 1'b1, pc_b, 1'b1, "R5 steer");
    probe(pc_a, 1, "R4 one miss keeps taken");
    step(pc_a, 1'b1, pc_a, 1'b0, "R6 miss 2");
    step(pc_b, 1'b1, pc_b, 1'b1, "R5 steer");
    step(pc_b, 1'b1, pc_b, 1'b1, "R5 steer");
    probe(pc_a, 0, "R4 two misses flip");

    // same-cycle lookup and update: pre-update value, new value next cycle
    @(negedge clk);
    fetch_pc = pc_a; res_valid = 1'b1; res_pc = pc_a; res_taken = 1'b1;
    #1;
    check("R7 same cycle pre-update", int'(pred), 0);
    @(posedge clk);
    m_ctr[3][m_idx(pc_a)] = 2;
    m_hist = 3;
    probe(pc_a, 1, "R7 update visible next cycle");

    // R8: resolve fields toggle while strobe low
    for (int i = 0; i < 4; i++) step(pc_a, 1'b0, pc_a, 1'b0, "R8 strobe low");
    probe(pc_a, 1, "R8 no effect");

    // R3 saturation at zero on B in set 0
    for (int i = 0; i < 6; i++) step(pc_b, 1'b1, pc_b, 1'b0, "R3 saturate low");
    probe(pc_b, 0, "R3 saturated not-taken");

    // constrained random traffic against model
    for (int n = 0; n < 4000; n++) begin
      logic [PC_W-1:0] f, r;
      f = {$urandom(), 2'b00};
      r = {$urandom(), 2'b00};
      f[IDX_W+1:2] = IDX_W'($urandom_range(0, 7));
      r[IDX_W+1:2] = IDX_W'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) r = f;
      step(f, ($urandom_range(0, 9) < 7), r, ($urandom_range(0, 9) < 6),
           "R2/R3/R5/R6/R7/R9 random");
    end

    finish_run();
  end
endmodule